// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block is the digital control half of a successive-approximation converter. All timing comes from a system-clock counter. A high-to-low transition on the active-low start input launches a conversion. For a fixed number of clock cycles the block holds its active-low busy output low. It then captures the value offered on a stub result input, which stands in for the analog array. A short acquisition window follows, during which a new start is refused.

The captured result reaches a 15-bit output register through one of two latching policies, chosen by a two-bit selector. In the immediate policy the register is written at the end of conversion. In the deferred policy the register is written when the next conversion is launched, so readers see data one sample late but have the whole conversion time to fetch it. A pad-enable output marks when the data bus may be driven: only while chip-select and read strobe are both low.

Two power inputs, nap and standby, block conversions while they are high. After both have fallen, a programmable wake-up wait must expire before a start is accepted. A start that lands in the wrong moment is never acted on. A start while busy raises a sticky overlap flag. A start that is refused for any other reason raises a sticky reject flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `rst` is high and after it, `busy_n` is 1, `overlap_err` and `reject_err` are 0, `data_out` is 0, and `data_oe` is 0 when `cs_n` or `rd_n` is high.
- R2: A start is the clock edge at which `start_n` is sampled low after being sampled high. An accepted start drives `busy_n` low from that edge for exactly CONV_CYCLES clock cycles.
- R3: With `lat_sel` = 2'b01 at the start, `data_out` takes the value of `result_in` at the same edge where `busy_n` rises.
- R4: With `lat_sel` = 2'b10 at the start, `data_out` is loaded at the start edge with the result captured at the end of the previous conversion, and is left unchanged at end of conversion.
- R5: A start with `lat_sel` = 2'b00 or 2'b11 launches no conversion: `busy_n` stays 1, `data_out` is unchanged and `reject_err` is set.
- R6: `data_oe` is 1 exactly when `cs_n` and `rd_n` are both 0.
- R7: A start while `busy_n` is low is ignored and sets the sticky `overlap_err`. The running conversion ends at its original time.
- R8: A start during the ACQ_CYCLES cycles after `busy_n` rises is refused (`busy_n` stays 1) and sets `reject_err`.
- R9: While `nap` or `stby` is 1, a start is refused (`busy_n` stays 1) and sets `reject_err`.
- R10: After `nap` falls, starts are refused for NAP_WAKE_CYCLES cycles. After `stby` falls, starts are refused for STBY_WAKE_CYCLES cycles. After that wait, a start is accepted.
- R11: `rst` high aborts a conversion: `busy_n` is 1 after that edge and the aborted conversion never loads `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; aborts any conversion |
| start_n | input | 1 | Active-low convert start; the falling edge launches a conversion |
| lat_sel | input | 2 | Latching policy: 01 immediate, 10 deferred, others invalid |
| nap | input | 1 | Light power-down request |
| stby | input | 1 | Deep power-down request |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| result_in | input | 15 | Stub conversion result, sampled at end of conversion |
| busy_n | output | 1 | Active-low conversion in progress |
| data_out | output | 15 | Output register contents |
| data_oe | output | 1 | Pad enable for the three-state data bus |
| overlap_err | output | 1 | Sticky: a start arrived during a conversion |
| reject_err | output | 1 | Sticky: a start was refused (mode, acquisition or power) |

## Verification
The start is sampled at clock edge P1, and `busy_n` and the deferred-mode load are visible right after P1. `busy_n` is still low after edge P(CONV_CYCLES) and high after edge P(CONV_CYCLES+1). The immediate-mode result appears together with that rise. The bench drives inputs on falling clock edges and counts falling edges from the start, so each check lands in the cycle its result is due. It also samples both the last low cycle and the first high cycle of `busy_n`. Refused starts are checked one cycle after the edge that saw them, through `busy_n` and the sticky flags. The wake-up wait is probed well inside its window and again after it.

// File: rtl/cvt_pkg.sv
`timescale 1ns/1ps
package cvt_pkg;
  typedef enum logic [1:0] {
    LAT_BAD_LO = 2'b00,
    LAT_EOC    = 2'b01,
    LAT_NEXT   = 2'b10,
    LAT_BAD_HI = 2'b11
  } lat_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_CONV = 2'b01,
    PH_ACQ  = 2'b10
  } phase_e;
endpackage

// File: rtl/cvt_edge.sv
`timescale 1ns/1ps
module cvt_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_n,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sig_n;
  end

  assign fall = prev_q & ~sig_n;
endmodule

// File: rtl/cvt_power.sv
`timescale 1ns/1ps
module cvt_power #(
  parameter int NAP_WAKE_CYCLES  = 60,
  parameter int STBY_WAKE_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic nap,
  input  logic stby,
  output logic ready
);
  localparam int MAXW = (NAP_WAKE_CYCLES > STBY_WAKE_CYCLES) ? NAP_WAKE_CYCLES : STBY_WAKE_CYCLES;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] wake_cnt;

  always_ff @(posedge clk) begin
    if (rst)                wake_cnt <= '0;
    else if (stby)          wake_cnt <= CW'(STBY_WAKE_CYCLES);
    else if (nap)           wake_cnt <= CW'(NAP_WAKE_CYCLES);
    else if (wake_cnt != 0) wake_cnt <= wake_cnt - 1'b1;
  end

  assign ready = !nap && !stby && (wake_cnt == '0);

  // R10: right after nap drops, the wake-up wait is still running
  p_wake_pending_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(nap) && !stby && !$past(rst)) |-> !ready);
endmodule

// File: rtl/cvt_seq.sv
`timescale 1ns/1ps
module cvt_seq
  import cvt_pkg::*;
#(
  parameter int CONV_CYCLES = 60,
  parameter int ACQ_CYCLES  = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy_n,
  output logic eoc,
  output logic idle,
  output logic in_conv
);
  localparam int MAXC = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  phase_e        phase;
  logic [CW-1:0] cnt;

  assign idle    = (phase == PH_IDLE);
  assign in_conv = (phase == PH_CONV);
  assign eoc     = in_conv && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      busy_n <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: if (go) begin
          phase  <= PH_CONV;
          cnt    <= CW'(CONV_CYCLES - 1);
          busy_n <= 1'b0;
        end
        PH_CONV: if (cnt == '0) begin
          phase  <= PH_ACQ;
          cnt    <= CW'(ACQ_CYCLES - 1);
          busy_n <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_ACQ: if (cnt == '0) phase <= PH_IDLE;
                else           cnt   <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: busy only drops in response to an accepted start
  p_busy_from_go_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> $past(go));
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import cvt_pkg::*;
#(
  parameter int DW               = 15,
  parameter int CONV_CYCLES      = 60,
  parameter int ACQ_CYCLES       = 14,
  parameter int NAP_WAKE_CYCLES  = 60,
  parameter int STBY_WAKE_CYCLES = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_n,
  input  logic [1:0]    lat_sel,
  input  logic          nap,
  input  logic          stby,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic [DW-1:0] result_in,
  output logic          busy_n,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          overlap_err,
  output logic          reject_err
);
  localparam int LW = $clog2(CONV_CYCLES + 2);

  logic      start_fall, ready, eoc, idle, in_conv, go, mode_ok;
  lat_mode_e cur_mode;
  logic [DW-1:0] pend_q;

  cvt_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .sig_n(start_n),
    .fall (start_fall)
  );

  cvt_power #(
    .NAP_WAKE_CYCLES (NAP_WAKE_CYCLES),
    .STBY_WAKE_CYCLES(STBY_WAKE_CYCLES)
  ) u_power (
    .clk  (clk),
    .rst  (rst),
    .nap  (nap),
    .stby (stby),
    .ready(ready)
  );

  cvt_seq #(
    .CONV_CYCLES(CONV_CYCLES),
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .busy_n (busy_n),
    .eoc    (eoc),
    .idle   (idle),
    .in_conv(in_conv)
  );

  assign mode_ok = (lat_sel == LAT_EOC) || (lat_sel == LAT_NEXT);
  assign go      = start_fall && idle && ready && mode_ok;
  assign data_oe = !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode    <= LAT_EOC;
      pend_q      <= '0;
      data_out    <= '0;
      overlap_err <= 1'b0;
      reject_err  <= 1'b0;
    end else begin
      if (go) cur_mode <= lat_mode_e'(lat_sel);
      if (eoc) pend_q <= result_in;
      if (eoc && cur_mode == LAT_EOC)
        data_out <= result_in;
      else if (go && lat_sel == LAT_NEXT)
        data_out <= pend_q;
      if (start_fall && in_conv)        overlap_err <= 1'b1;
      else if (start_fall && !go)       reject_err  <= 1'b1;
    end
  end

  // Checker state: length of the current busy-low stretch
  logic [LW-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || busy_n) low_run <= '0;
    else               low_run <= low_run + 1'b1;
  end

  // R2: busy never stays low past the conversion window
  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    low_run <= LW'(CONV_CYCLES));

  // R3: immediate policy shows the stub result as busy rises
  p_eoc_load_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_n) && !$past(rst) && cur_mode == LAT_EOC) |-> data_out == $past(result_in));

  // R7: a start seen during a conversion raises the overlap flag
  p_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    (start_fall && !busy_n) |=> overlap_err);

  // R9: while powered down an idle block does not start
  p_asleep_r9: assert property (@(posedge clk) disable iff (rst)
    ((nap || stby) && busy_n) |=> busy_n);

  // R11: the edge after reset leaves busy released
  p_abort_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy_n);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  localparam int DW    = 15;
  localparam int CONV  = 60;
  localparam int ACQ   = 14;
  localparam int NWAKE = 60;
  localparam int SWAKE = 200;
  localparam int NVEC  = 10;

  // {lat_sel[32:31], result[30:16], expected data_out[15:1], expected reject_err[0]}
  localparam logic [32:0] VEC [NVEC] = '{
    {2'b01, 15'h1234, 15'h1234, 1'b0},
    {2'b01, 15'h7FFF, 15'h7FFF, 1'b0},
    {2'b10, 15'h0ABC, 15'h7FFF, 1'b0},
    {2'b10, 15'h0001, 15'h0ABC, 1'b0},
    {2'b10, 15'h4000, 15'h0001, 1'b0},
    {2'b01, 15'h0000, 15'h0000, 1'b0},
    {2'b10, 15'h5555, 15'h0000, 1'b0},
    {2'b00, 15'h3333, 15'h0000, 1'b1},
    {2'b11, 15'h6666, 15'h0000, 1'b1},
    {2'b10, 15'h2AAA, 15'h5555, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1, start_n = 1'b1, nap = 1'b0, stby = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1;
  logic [1:0] lat_sel = 2'b01;
  logic [DW-1:0] result_in = '0;
  logic busy_n, data_oe, overlap_err, reject_err;
  logic [DW-1:0] data_out;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(
    .DW(DW), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ),
    .NAP_WAKE_CYCLES(NWAKE), .STBY_WAKE_CYCLES(SWAKE)
  ) u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .start_n(start_n), .lat_sel(lat_sel),
    .nap(nap), .stby(stby), .cs_n(cs_n), .rd_n(rd_n), .result_in(result_in),
    .busy_n(busy_n), .data_out(data_out), .data_oe(data_oe),
    .overlap_err(overlap_err), .reject_err(reject_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start_n = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  // Issue a start at a falling edge; returns after the start-sampling edge P1
  task automatic pulse_start();
    @(negedge clk); start_n = 1'b0;
    @(negedge clk); start_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: idle state after reset
    check("R1 busy_n", busy_n, 1);
    check("R1 overlap_err", overlap_err, 0);
    check("R1 reject_err", reject_err, 0);
    check("R1 data_oe off", data_oe, 0);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check("R1 data_out", data_out, 0);
    check("R6 data_oe on", data_oe, 1);
    rd_n = 1'b1; #1;
    check("R6 read high", data_oe, 0);
    rd_n = 1'b0; cs_n = 1'b1; #1;
    check("R6 cs high", data_oe, 0);
    cs_n = 1'b0;

    // Vector walk: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      lat_sel   = VEC[i][32:31];
      result_in = VEC[i][30:16];
      pulse_start();
      if (VEC[i][32:31] == 2'b01 || VEC[i][32:31] == 2'b10) begin
        check($sformatf("R2 busy low at start v%0d", i), busy_n, 0);
        repeat (CONV - 1) @(negedge clk);
        check($sformatf("R2 busy low last cycle v%0d", i), busy_n, 0);
        @(negedge clk);
        check($sformatf("R2 busy high after window v%0d", i), busy_n, 1);
      end else begin
        check($sformatf("R5 no conversion v%0d", i), busy_n, 1);
        repeat (CONV) @(negedge clk);
      end
      check($sformatf("R3/R4/R5 data v%0d", i), data_out, VEC[i][15:1]);
      check($sformatf("R5 reject flag v%0d", i), reject_err, VEC[i][0]);
      repeat (ACQ + 2) @(negedge clk);
    end

    // R7: start during conversion ignored, end time unchanged
    do_reset();
    lat_sel = 2'b01; result_in = 15'h0F0F;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    check("R7 overlap flag", overlap_err, 1);
    check("R7 still busy", busy_n, 0);
    repeat (CONV - 13) @(negedge clk);
    check("R7 busy low last cycle", busy_n, 0);
    @(negedge clk);
    check("R7 busy rises on time", busy_n, 1);
    check("R7 reject untouched", reject_err, 0);

    // R8: start during acquisition refused
    start_n = 1'b0;
    @(negedge clk); start_n = 1'b1;
    check("R8 no start in acquisition", busy_n, 1);
    check("R8 reject flag", reject_err, 1);
    @(negedge clk);
    check("R7 overlap still sticky", overlap_err, 1);

    // R9 / R10: nap
    do_reset();
    nap = 1'b1;
    pulse_start();
    check("R9 nap blocks start", busy_n, 1);
    check("R9 reject flag", reject_err, 1);
    @(negedge clk); nap = 1'b0;
    repeat (20) @(negedge clk);
    pulse_start();
    check("R10 start during nap wake refused", busy_n, 1);
    repeat (NWAKE) @(negedge clk);
    pulse_start();
    check("R10 start after nap wake accepted", busy_n, 0);
    repeat (CONV + ACQ + 4) @(negedge clk);

    // R9 / R10: standby
    @(negedge clk); stby = 1'b1;
    pulse_start();
    check("R9 stby blocks start", busy_n, 1);
    @(negedge clk); stby = 1'b0;
    repeat (NWAKE + 20) @(negedge clk);
    pulse_start();
    check("R10 start during stby wake refused", busy_n, 1);
    repeat (SWAKE) @(negedge clk);
    pulse_start();
    check("R10 start after stby wake accepted", busy_n, 0);
    repeat (CONV + ACQ + 4) @(negedge clk);

    // R11: reset aborts a conversion, no late load
    do_reset();
    lat_sel = 2'b01; result_in = 15'h7ABC;
    pulse_start();
    check("R11 conversion running", busy_n, 0);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R11 busy released", busy_n, 1);
    repeat (CONV + 5) @(negedge clk);
    check("R11 no load after abort", data_out, 0);
    check("R11 still idle", busy_n, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule